// File: doc/BRIEF.md
# System-Management Entry and Resume Sequencer

This block sequences a processor core into and out of system-management mode. A management interrupt request, raised outside that mode, makes the block record the interrupted instruction pointer and privilege level in a small register-file save map. The block then switches the core into management mode and redirects fetch to a handler address. That address is the current relocation base plus 0x8000. While in management mode the core addresses memory physically, so translation is switched off.

The handler can rewrite slots of the save map through a write port that accepts an offset within the save area. A resume command ends management mode. Fetch then returns to whatever instruction pointer the save map holds, at whatever privilege level it holds. The base slot is copied into the live relocation register at the same moment, so a new base only moves the handler on the following entry. A request that arrives during management mode is held and taken right after resume. A resume issued outside the mode does nothing except raise an error pulse.

Top module: `sysmgmt_seq`

## Requirements
- R1: After reset the block is outside management mode: `in_smm`=0, `xlate_en`=1, `smi_pending`=0, `redirect`=0, `redirect_addr`=0, `redirect_pl`=0, `rsm_err`=0. The relocation base and its save slot both hold 0x30000.
- R2: An `smi_req` sampled outside management mode causes the following at the next clock: `in_smm`=1, a one-cycle `redirect` with `redirect_addr` = base + 0x8000, and `redirect_pl`=0. Only such a request, or a held one, enters the mode.
- R3: On entry, `cur_ip` and `cur_pl` are recorded. An unmodified resume then pulses `redirect` with exactly those values and clears `in_smm` at the next clock. Only a resume leaves the mode.
- R4: The base slot sits at save offset 0x7EF8. A value written there during management mode does not move the handler of the current stay. It is copied into the live base at resume and is used from the next entry on.
- R5: A write at offset 0x7FF0 (instruction pointer slot) or 0x7FA8 (privilege slot, bits 1:0) during management mode changes where, and at what level, the next resume continues.
- R6: Save-map writes issued outside management mode, and writes to any other offset, change nothing seen at later resumes or entries.
- R7: An `smi_req` during management mode sets `smi_pending`. A held request makes the block re-enter management mode on the clock after the resume takes effect, and `smi_pending` then clears.
- R8: `rsm_cmd` outside management mode gives a one-cycle `rsm_err` at the next clock and leaves all other outputs and state unchanged.
- R9: `xlate_en` is low exactly while `in_smm` is high.
- R10: If a save-map write and a resume occur in the same cycle, the resume uses the slot contents from before that write. The write still lands in the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req | input | 1 | Management interrupt request, sampled each clock |
| rsm_cmd | input | 1 | Resume command |
| cur_ip | input | 32 | Instruction pointer of the interrupted stream |
| cur_pl | input | 2 | Privilege level of the interrupted stream |
| map_wr_en | input | 1 | Save-map write strobe from the handler |
| map_wr_ofs | input | 16 | Offset within the save area |
| map_wr_data | input | 32 | Save-map write data |
| in_smm | output | 1 | High while in management mode |
| smi_pending | output | 1 | A request is being held for after resume |
| xlate_en | output | 1 | Address translation allowed (low in management mode) |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr | output | 32 | Fetch target of the last redirect |
| redirect_pl | output | 2 | Privilege level for the last redirect |
| rsm_err | output | 1 | Resume issued outside management mode |

## Verification
The assertions assume that inputs are fully known after reset. They also assume that a change of `in_smm` can only come from a request or a resume sampled on the previous clock. No assumption is made about how requests, resumes and writes overlap. The stimulus therefore drives every input to a defined value on each cycle, away from the clock edge. It freely mixes requests during management mode, resumes outside it, and writes combined with resumes, so every assertion is exercised inside its legal input space.

// File: rtl/sysmgmt_pkg.sv
package sysmgmt_pkg;
  typedef enum logic [1:0] {
    SLOT_IP   = 2'd0,
    SLOT_PL   = 2'd1,
    SLOT_BASE = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  typedef enum logic {
    ST_NORMAL = 1'b0,
    ST_SMM    = 1'b1
  } mode_e;

  localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/sysmgmt_slot_dec.sv
module sysmgmt_slot_dec
  import sysmgmt_pkg::*;
#(
  parameter int              OFS_W    = 16,
  parameter logic [OFS_W-1:0] OFS_IP   = 16'h7FF0,
  parameter logic [OFS_W-1:0] OFS_PL   = 16'h7FA8,
  parameter logic [OFS_W-1:0] OFS_BASE = 16'h7EF8
) (
  input  logic [OFS_W-1:0] ofs,
  output slot_e            slot,
  output logic             hit
);
  always_comb begin
    unique case (ofs)
      OFS_IP:   slot = SLOT_IP;
      OFS_PL:   slot = SLOT_PL;
      OFS_BASE: slot = SLOT_BASE;
      default:  slot = SLOT_NONE;
    endcase
    hit = (slot != SLOT_NONE);
  end
endmodule

// File: rtl/sysmgmt_savemap.sv
module sysmgmt_savemap
  import sysmgmt_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                PL_W       = 2,
  parameter logic [DATA_W-1:0] RESET_BASE = 32'h0003_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_smm,
  input  logic              hw_wr_en,
  input  slot_e             hw_slot,
  input  logic [DATA_W-1:0] hw_data,
  input  logic              save_en,
  input  logic [DATA_W-1:0] save_ip,
  input  logic [PL_W-1:0]   save_pl,
  output logic [DATA_W-1:0] rd_ip,
  output logic [PL_W-1:0]   rd_pl,
  output logic [DATA_W-1:0] rd_base
);
  localparam int PAD_W = DATA_W - PL_W;

  logic [DATA_W-1:0] slot_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [DATA_W-1:0] INIT = (g == int'(SLOT_BASE)) ? RESET_BASE : '0;
    logic              save_hit;
    logic [DATA_W-1:0] save_val;

    always_comb begin
      save_hit = save_en && ((g == int'(SLOT_IP)) || (g == int'(SLOT_PL)));
      save_val = (g == int'(SLOT_IP)) ? save_ip : {{PAD_W{1'b0}}, save_pl};
    end

    always_ff @(posedge clk) begin
      if (rst)
        slot_q[g] <= INIT;
      else if (save_hit)
        slot_q[g] <= save_val;
      else if (hw_wr_en && in_smm && (int'(hw_slot) == g))
        slot_q[g] <= hw_data;
    end
  end

  assign rd_ip   = slot_q[SLOT_IP];
  assign rd_pl   = slot_q[SLOT_PL][PL_W-1:0];
  assign rd_base = slot_q[SLOT_BASE];

  AST_MAP_FROZEN_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (!in_smm && !save_en) |=> $stable(rd_base)) else $error("base slot changed outside mode"); // R6
endmodule

// File: rtl/sysmgmt_fsm.sv
module sysmgmt_fsm
  import sysmgmt_pkg::*;
#(
  parameter int                IP_W        = 32,
  parameter int                PL_W        = 2,
  parameter logic [IP_W-1:0]   RESET_BASE  = 32'h0003_0000,
  parameter logic [IP_W-1:0]   HANDLER_OFS = 32'h0000_8000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smi_req,
  input  logic            rsm_cmd,
  input  logic [IP_W-1:0] rd_ip,
  input  logic [PL_W-1:0] rd_pl,
  input  logic [IP_W-1:0] rd_base,
  output logic            save_en,
  output logic            in_smm,
  output logic            smi_pending,
  output logic            xlate_en,
  output logic            redirect,
  output logic [IP_W-1:0] redirect_addr,
  output logic [PL_W-1:0] redirect_pl,
  output logic            rsm_err
);
  mode_e           mode_q;
  logic            pend_q;
  logic [IP_W-1:0] base_q;
  logic            enter;
  logic            leave;

  always_comb begin
    enter   = (mode_q == ST_NORMAL) && (smi_req || pend_q);
    leave   = (mode_q == ST_SMM) && rsm_cmd;
    save_en = enter;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= ST_NORMAL;
      pend_q        <= 1'b0;
      base_q        <= RESET_BASE;
      xlate_en      <= 1'b1;
      redirect      <= 1'b0;
      redirect_addr <= '0;
      redirect_pl   <= '0;
      rsm_err       <= 1'b0;
    end else begin
      redirect <= 1'b0;
      rsm_err  <= (mode_q == ST_NORMAL) && rsm_cmd;
      if (enter) begin
        mode_q        <= ST_SMM;
        pend_q        <= 1'b0;
        xlate_en      <= 1'b0;
        redirect      <= 1'b1;
        redirect_addr <= base_q + HANDLER_OFS;
        redirect_pl   <= '0;
      end else if (leave) begin
        mode_q        <= ST_NORMAL;
        pend_q        <= pend_q | smi_req;
        base_q        <= rd_base;
        xlate_en      <= 1'b1;
        redirect      <= 1'b1;
        redirect_addr <= rd_ip;
        redirect_pl   <= rd_pl;
      end else if (mode_q == ST_SMM) begin
        pend_q <= pend_q | smi_req;
      end
    end
  end

  assign in_smm      = (mode_q == ST_SMM);
  assign smi_pending = pend_q;

  AST_ENTRY_NEEDS_SMI: assert property (@(posedge clk) disable iff (rst)
    $rose(in_smm) |-> $past(smi_req || smi_pending)) else $error("entry without request"); // R2
  AST_EXIT_NEEDS_RSM: assert property (@(posedge clk) disable iff (rst)
    $fell(in_smm) |-> $past(rsm_cmd)) else $error("exit without resume"); // R3
  AST_ENTRY_TARGET: assert property (@(posedge clk) disable iff (rst)
    $rose(in_smm) |-> (redirect && redirect_pl == '0)) else $error("bad entry redirect"); // R2
  AST_NO_XLATE_IN_SMM: assert property (@(posedge clk) disable iff (rst)
    xlate_en != in_smm) else $error("translation on in mode"); // R9
  AST_ERR_ONLY_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    rsm_err |-> $past(rsm_cmd && !in_smm)) else $error("spurious error"); // R8
  AST_REDIRECT_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (in_smm != $past(in_smm))) else $error("redirect without switch"); // R3
  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (smi_pending && !in_smm) |=> (in_smm && !smi_pending)) else $error("held request not taken"); // R7
endmodule

// File: rtl/sysmgmt_seq.sv
module sysmgmt_seq
  import sysmgmt_pkg::*;
#(
  parameter int               IP_W        = 32,
  parameter int               PL_W        = 2,
  parameter int               OFS_W       = 16,
  parameter logic [IP_W-1:0]  RESET_BASE  = 32'h0003_0000,
  parameter logic [IP_W-1:0]  HANDLER_OFS = 32'h0000_8000,
  parameter logic [OFS_W-1:0] OFS_IP      = 16'h7FF0,
  parameter logic [OFS_W-1:0] OFS_PL      = 16'h7FA8,
  parameter logic [OFS_W-1:0] OFS_BASE    = 16'h7EF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smi_req,
  input  logic             rsm_cmd,
  input  logic [IP_W-1:0]  cur_ip,
  input  logic [PL_W-1:0]  cur_pl,
  input  logic             map_wr_en,
  input  logic [OFS_W-1:0] map_wr_ofs,
  input  logic [IP_W-1:0]  map_wr_data,
  output logic             in_smm,
  output logic             smi_pending,
  output logic             xlate_en,
  output logic             redirect,
  output logic [IP_W-1:0]  redirect_addr,
  output logic [PL_W-1:0]  redirect_pl,
  output logic             rsm_err
);
  slot_e           wr_slot;
  logic            wr_hit;
  logic            save_en;
  logic [IP_W-1:0] rd_ip;
  logic [PL_W-1:0] rd_pl;
  logic [IP_W-1:0] rd_base;

  sysmgmt_slot_dec #(
    .OFS_W(OFS_W), .OFS_IP(OFS_IP), .OFS_PL(OFS_PL), .OFS_BASE(OFS_BASE)
  ) u_dec (
    .ofs (map_wr_ofs),
    .slot(wr_slot),
    .hit (wr_hit)
  );

  sysmgmt_savemap #(
    .DATA_W(IP_W), .PL_W(PL_W), .RESET_BASE(RESET_BASE)
  ) u_map (
    .clk     (clk),
    .rst     (rst),
    .in_smm  (in_smm),
    .hw_wr_en(map_wr_en && wr_hit),
    .hw_slot (wr_slot),
    .hw_data (map_wr_data),
    .save_en (save_en),
    .save_ip (cur_ip),
    .save_pl (cur_pl),
    .rd_ip   (rd_ip),
    .rd_pl   (rd_pl),
    .rd_base (rd_base)
  );

  sysmgmt_fsm #(
    .IP_W(IP_W), .PL_W(PL_W), .RESET_BASE(RESET_BASE), .HANDLER_OFS(HANDLER_OFS)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .smi_req      (smi_req),
    .rsm_cmd      (rsm_cmd),
    .rd_ip        (rd_ip),
    .rd_pl        (rd_pl),
    .rd_base      (rd_base),
    .save_en      (save_en),
    .in_smm       (in_smm),
    .smi_pending  (smi_pending),
    .xlate_en     (xlate_en),
    .redirect     (redirect),
    .redirect_addr(redirect_addr),
    .redirect_pl  (redirect_pl),
    .rsm_err      (rsm_err)
  );

  AST_RESUME_USES_OLD_SLOT: assert property (@(posedge clk) disable iff (rst)
    (in_smm && rsm_cmd) |=> (redirect_addr == $past(rd_ip))) else $error("resume target wrong"); // R10
endmodule

// File: tb/test_sysmgmt_seq.sv
`timescale 1ns/1ps
module test_sysmgmt_seq;
  localparam logic [15:0] O_IP   = 16'h7FF0;
  localparam logic [15:0] O_PL   = 16'h7FA8;
  localparam logic [15:0] O_BASE = 16'h7EF8;
  localparam logic [15:0] O_JUNK = 16'h7E00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smi_req = 1'b0, rsm_cmd = 1'b0, map_wr_en = 1'b0;
  logic [31:0] cur_ip = '0, map_wr_data = '0;
  logic [1:0]  cur_pl = '0;
  logic [15:0] map_wr_ofs = '0;
  logic        in_smm, smi_pending, xlate_en, redirect, rsm_err;
  logic [31:0] redirect_addr;
  logic [1:0]  redirect_pl;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit          m_in, m_pend, m_red, m_err;
  logic [31:0] m_addr, m_base, s_ip, s_pl, s_base;
  logic [1:0]  m_pl;

  always #4 clk = ~clk;

  sysmgmt_seq i_sysmgmt_seq (
    .clk(clk), .rst(rst), .smi_req(smi_req), .rsm_cmd(rsm_cmd),
    .cur_ip(cur_ip), .cur_pl(cur_pl), .map_wr_en(map_wr_en),
    .map_wr_ofs(map_wr_ofs), .map_wr_data(map_wr_data),
    .in_smm(in_smm), .smi_pending(smi_pending), .xlate_en(xlate_en),
    .redirect(redirect), .redirect_addr(redirect_addr),
    .redirect_pl(redirect_pl), .rsm_err(rsm_err)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "in_smm", 32'(in_smm), 32'(m_in));
    chk(tag, "smi_pending", 32'(smi_pending), 32'(m_pend));
    chk(tag, "xlate_en", 32'(xlate_en), 32'(!m_in));
    chk(tag, "redirect", 32'(redirect), 32'(m_red));
    chk(tag, "redirect_addr", redirect_addr, m_addr);
    chk(tag, "redirect_pl", 32'(redirect_pl), 32'(m_pl));
    chk(tag, "rsm_err", 32'(rsm_err), 32'(m_err));
  endtask

  task automatic model_reset();
    m_in = 0; m_pend = 0; m_red = 0; m_err = 0; m_addr = '0; m_pl = '0;
    m_base = 32'h0003_0000; s_base = 32'h0003_0000; s_ip = '0; s_pl = '0;
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic cyc(string tag, bit smi, bit rsm, bit wr, logic [15:0] ofs,
                     logic [31:0] wd, logic [31:0] ip, logic [1:0] pl);
    logic [31:0] o_ip, o_pl, o_base;
    smi_req = smi; rsm_cmd = rsm; map_wr_en = wr; map_wr_ofs = ofs;
    map_wr_data = wd; cur_ip = ip; cur_pl = pl;
    m_red = 0; m_err = 0;
    if (m_in) begin
      o_ip = s_ip; o_pl = s_pl; o_base = s_base;
      if (wr) begin
        if (ofs == O_IP) s_ip = wd;
        else if (ofs == O_PL) s_pl = wd;
        else if (ofs == O_BASE) s_base = wd;
      end
      m_pend = m_pend | smi;
      if (rsm) begin
        m_in = 0; m_red = 1; m_addr = o_ip; m_pl = o_pl[1:0]; m_base = o_base;
      end
    end else begin
      m_err = rsm;
      if (smi || m_pend) begin
        m_in = 1; m_pend = 0; s_ip = ip; s_pl = {30'b0, pl};
        m_red = 1; m_addr = m_base + 32'h8000; m_pl = 2'd0;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, O_JUNK, 32'h0, 32'h0, 2'd0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");  // reset values
    idle("R1");
    // first entry uses reset base 0x30000 -> 0x38000
    cyc("R2", 1, 0, 0, O_JUNK, 0, 32'h1234_5670, 2'd3);
    chk("R2", "entry addr", redirect_addr, 32'h0003_8000);
    idle("R9");
    // plain resume returns to saved ip/pl
    cyc("R3", 0, 1, 0, O_JUNK, 0, 32'hAAAA_0000, 2'd1);
    chk("R3", "resume addr", redirect_addr, 32'h1234_5670);
    // resume outside the mode
    cyc("R8", 0, 1, 0, O_JUNK, 0, 32'h0, 2'd0);
    idle("R8");
    // relocation: new base only after resume
    cyc("R4", 1, 0, 0, O_JUNK, 0, 32'h0000_1000, 2'd2);
    cyc("R4", 0, 0, 1, O_BASE, 32'h0005_0000, 0, 0);
    cyc("R4", 0, 1, 0, O_JUNK, 0, 0, 0);
    chk("R4", "resume after base write", redirect_addr, 32'h0000_1000);
    cyc("R4", 1, 0, 0, O_JUNK, 0, 32'h0000_2000, 2'd0);
    chk("R4", "relocated entry", redirect_addr, 32'h0005_8000);
    // rewrite ip and privilege
    cyc("R5", 0, 0, 1, O_IP, 32'hDEAD_0000, 0, 0);
    cyc("R5", 0, 0, 1, O_PL, 32'h0000_0001, 0, 0);
    cyc("R5", 0, 1, 0, O_JUNK, 0, 0, 0);
    chk("R5", "rewritten ip", redirect_addr, 32'hDEAD_0000);
    chk("R5", "rewritten pl", 32'(redirect_pl), 32'd1);
    // writes outside and to other offsets are ignored
    cyc("R6", 0, 0, 1, O_BASE, 32'h0009_0000, 0, 0);
    cyc("R6", 1, 0, 0, O_JUNK, 0, 32'h0000_3000, 2'd2);
    chk("R6", "base unchanged", redirect_addr, 32'h0005_8000);
    cyc("R6", 0, 0, 1, O_JUNK, 32'hFFFF_FFFF, 0, 0);
    cyc("R6", 0, 1, 0, O_JUNK, 0, 0, 0);
    chk("R6", "ip unchanged", redirect_addr, 32'h0000_3000);
    // held request
    cyc("R7", 1, 0, 0, O_JUNK, 0, 32'h0000_4000, 2'd3);
    cyc("R7", 1, 0, 0, O_JUNK, 0, 0, 0);
    chk("R7", "pending set", 32'(smi_pending), 32'd1);
    cyc("R7", 0, 1, 0, O_JUNK, 0, 0, 0);
    cyc("R7", 0, 0, 0, O_JUNK, 0, 32'h0000_5000, 2'd1);
    chk("R7", "re-entered", 32'(in_smm), 32'd1);
    // write and resume together
    cyc("R10", 0, 1, 1, O_IP, 32'hBEEF_0000, 0, 0);
    chk("R10", "old ip used", redirect_addr, 32'h0000_5000);
    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [15:0] o;
      k = $urandom_range(0, 3);
      o = (k == 0) ? O_IP : (k == 1) ? O_PL : (k == 2) ? O_BASE : O_JUNK;
      cyc("R9", ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 2) == 0), o, $urandom, $urandom, 2'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule